// File: doc/BRIEF.md
# Double-Edge Strobed DMA Write Burst Receiver

This block sits on the device side of a parallel disk-style link. It receives a host-to-device DMA burst whose words are clocked by both edges of a strobe from the host. The strobe, the 16-bit data bus and the host's acknowledge and stop lines are brought through a two-flop synchronizer into the fast system clock. A change between two consecutive synchronized strobe samples counts as one word. Each captured word goes into a small FIFO, which is drained through a valid/ready port.

The device raises its request line whenever the FIFO has more free slots than a pause threshold. It then waits for the host to assert its active-low acknowledge and to release stop, and only after that does it drive its own active-low ready line. Ready is withdrawn as soon as free space falls to the threshold, so the host pauses while the remaining slots absorb words already in flight. The host ends the burst by raising stop. The block then drops request and ready, pulses a done flag with the number of words it stored, and returns to idle. A strobe edge that arrives while the FIFO is full is discarded and sets a sticky overflow flag.

Top module: `udma_rx_burst`

## Requirements
- R1: While reset is held and on the first cycle after it, devReq is 0, devReadyN is 1, outValid is 0, overflow is 0 and burstDone is 0.
- R2: When idle and the FIFO has more than PAUSE_FREE free slots, devReq goes to 1 within a few cycles. It stays 1 until the host terminates the burst.
- R3: Until the synchronized hostAckN is 0 and the synchronized hostStop is 0, devReadyN stays 1 and strobe edges store nothing.
- R4: During a burst, every rising edge and every falling edge of hostStrobe stores the hostData value present at that edge. Words leave on outData in arrival order, and a word is removed only on a cycle with outValid=1 and outReady=1. While outValid=1 and outReady=0, outData holds its value.
- R5: During a burst, devReadyN is 0 while free slots (DEPTH minus occupancy) exceed PAUSE_FREE and 1 once free slots are PAUSE_FREE or fewer. It returns to 0 when draining restores the space.
- R6: Any gap between strobe edges is accepted: after a long pause the burst is still open and the next edge stores its word.
- R7: hostStop=1 during a burst ends it. burstDone is then 1 for exactly one cycle, with devReq=0, devReadyN=1 and burstWords equal to the number of words stored in that burst. Afterwards the block goes back to idle and requests again when space allows.
- R8: A strobe edge with the FIFO full (DEPTH words) is dropped and does not count. It sets overflow, which stays 1 until reset.
- R9: A store and a removal in the same cycle both take effect: no word is lost, duplicated or reordered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hostStrobe | input | 1 | Host data strobe, asynchronous; both edges carry a word |
| hostData | input | DATA_W | Host data bus, asynchronous |
| hostAckN | input | 1 | Host DMA acknowledge, active low, asynchronous |
| hostStop | input | 1 | Host stop / burst termination, asynchronous |
| devReq | output | 1 | Device DMA request, active high |
| devReadyN | output | 1 | Device ready for data, active low |
| outData | output | DATA_W | Head-of-FIFO word |
| outValid | output | 1 | outData holds a word |
| outReady | input | 1 | Consumer takes the word on this cycle |
| overflow | output | 1 | Sticky: a word was dropped because the FIFO was full |
| burstDone | output | 1 | One-cycle pulse at burst termination |
| burstWords | output | CNT_W | Words stored in the current/last burst; final when burstDone is 1 |

## Verification
A synchronized strobe edge can be stored on the same clock that the consumer pops the head word, so the FIFO pointers and the occupancy counter must update together. The bench provokes this by holding outReady high while it toggles the strobe on every clock. Every push after the first then coincides with the pop of the word before it. The bench records every word that leaves and judges the case by exact order and count, and by the overflow flag staying clear. A second pairing, an edge against a full FIFO, is forced by ignoring the ready line, and is judged by the drained contents and the reported count.

// File: rtl/udma_rx_pkg.sv
`timescale 1ns/1ps
package udma_rx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_XFER = 2'd2,
    ST_DONE = 2'd3
  } rxState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic captureEn;
    logic clearCount;
  } dpCtrl_t;

  // status from datapath to control
  typedef struct packed {
    logic ackOn;
    logic stopOn;
    logic roomOk;
  } dpStat_t;

endpackage

// File: rtl/udma_rx_sync.sv
`timescale 1ns/1ps
module udma_rx_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stg [STAGES];

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stg[0] <= RST_VAL;
          else       stg[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stg[i] <= RST_VAL;
          else       stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/udma_rx_dp.sv
`timescale 1ns/1ps
module udma_rx_dp
  import udma_rx_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int DEPTH      = 8,
  parameter int PAUSE_FREE = 2,
  parameter int CNT_W      = 16,
  parameter int SYNC_STG   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostStrobe,
  input  logic [DATA_W-1:0] hostData,
  input  logic              hostAckN,
  input  logic              hostStop,
  input  dpCtrl_t           ctl,
  output dpStat_t           stat,
  output logic [DATA_W-1:0] outData,
  output logic              outValid,
  input  logic              outReady,
  output logic              overflow,
  output logic [CNT_W-1:0]  wordCount
);

  localparam int SW    = DATA_W + 3;
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam logic [SW-1:0] SYNC_RST = {3'b011, {DATA_W{1'b0}}};

  // all host inputs share one synchronizer so their order is kept
  logic [SW-1:0]     syncIn, syncOut;
  logic              strobeS, ackNS, stopS, strobeLast;
  logic [DATA_W-1:0] dataS;

  assign syncIn = {hostStrobe, hostAckN, hostStop, hostData};

  udma_rx_sync #(.W(SW), .STAGES(SYNC_STG), .RST_VAL(SYNC_RST)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  (syncIn),
    .dout (syncOut)
  );

  assign {strobeS, ackNS, stopS, dataS} = syncOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) strobeLast <= 1'b0;
    else       strobeLast <= strobeS;
  end

  logic strobeEvt;
  assign strobeEvt = strobeS ^ strobeLast;

  // FIFO
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [LVL_W-1:0]  level, freeSlots;
  logic              full, push, drop, pop;

  assign full      = (level == LVL_W'(DEPTH));
  assign push      = ctl.captureEn && strobeEvt && !full;
  assign drop      = ctl.captureEn && strobeEvt && full;
  assign outValid  = (level != '0);
  assign pop       = outValid && outReady;
  assign outData   = mem[rdPtr];
  assign freeSlots = LVL_W'(DEPTH) - level;

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= dataS;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     overflow <= 1'b0;
    else if (drop) overflow <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               wordCount <= '0;
    else if (ctl.clearCount) wordCount <= '0;
    else if (push)           wordCount <= wordCount + 1'b1;
  end

  assign stat.ackOn  = !ackNS;
  assign stat.stopOn = stopS;
  assign stat.roomOk = (freeSlots > LVL_W'(PAUSE_FREE));

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    level <= LVL_W'(DEPTH)); // R8
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (drop && !pop) |=> $stable(level)); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow); // R8
  AST_IGNORE_CLOSED: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.captureEn && !pop) |=> $stable(level)); // R3
  AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData))); // R4

endmodule

// File: rtl/udma_rx_ctrl.sv
`timescale 1ns/1ps
module udma_rx_ctrl
  import udma_rx_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  dpStat_t stat,
  output dpCtrl_t ctl,
  output logic    devReq,
  output logic    devReadyN,
  output logic    burstDone
);

  rxState_e state, stateNext;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (stat.roomOk) stateNext = ST_REQ;
      ST_REQ:  if (stat.ackOn && !stat.stopOn) stateNext = ST_XFER;
      ST_XFER: if (stat.stopOn) stateNext = ST_DONE;
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign devReq         = (state == ST_REQ) || (state == ST_XFER);
  assign devReadyN      = !((state == ST_XFER) && stat.roomOk);
  assign burstDone      = (state == ST_DONE);
  assign ctl.captureEn  = (state == ST_XFER);
  assign ctl.clearCount = (state == ST_REQ);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    burstDone |=> !burstDone); // R7
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    burstDone |-> (!devReq && devReadyN)); // R7
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (devReq && !stat.stopOn) |=> devReq); // R2
  AST_READY_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    !devReadyN |-> (ctl.captureEn && stat.roomOk)); // R5

endmodule

// File: rtl/udma_rx_burst.sv
`timescale 1ns/1ps
module udma_rx_burst
  import udma_rx_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int DEPTH      = 8,
  parameter int PAUSE_FREE = 2,
  parameter int CNT_W      = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostStrobe,
  input  logic [DATA_W-1:0] hostData,
  input  logic              hostAckN,
  input  logic              hostStop,
  output logic              devReq,
  output logic              devReadyN,
  output logic [DATA_W-1:0] outData,
  output logic              outValid,
  input  logic              outReady,
  output logic              overflow,
  output logic              burstDone,
  output logic [CNT_W-1:0]  burstWords
);

  dpCtrl_t ctl;
  dpStat_t stat;

  udma_rx_dp #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .PAUSE_FREE(PAUSE_FREE), .CNT_W(CNT_W), .SYNC_STG(2)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .hostStrobe (hostStrobe),
    .hostData   (hostData),
    .hostAckN   (hostAckN),
    .hostStop   (hostStop),
    .ctl        (ctl),
    .stat       (stat),
    .outData    (outData),
    .outValid   (outValid),
    .outReady   (outReady),
    .overflow   (overflow),
    .wordCount  (burstWords)
  );

  udma_rx_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .stat      (stat),
    .ctl       (ctl),
    .devReq    (devReq),
    .devReadyN (devReadyN),
    .burstDone (burstDone)
  );

endmodule

// File: tb/udma_rx_burst_bench.sv
`timescale 1ns/1ps
module udma_rx_burst_bench;

  localparam int DW = 16;
  localparam int DEPTH = 8;
  localparam int PAUSE_FREE = 2;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          hostStrobe = 1'b0;
  logic [DW-1:0] hostData = '0;
  logic          hostAckN = 1'b1;
  logic          hostStop = 1'b1;
  logic          devReq, devReadyN, outValid, overflow, burstDone;
  logic [DW-1:0] outData;
  logic          outReady = 1'b0;
  logic [CW-1:0] burstWords;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  logic [DW-1:0] recv [64];
  int recvCnt = 0;

  always #2.5 clk = ~clk;

  udma_rx_burst #(.DATA_W(DW), .DEPTH(DEPTH), .PAUSE_FREE(PAUSE_FREE), .CNT_W(CW)) u_udma_rx_burst (
    .clk(clk), .rstN(rstN), .hostStrobe(hostStrobe), .hostData(hostData),
    .hostAckN(hostAckN), .hostStop(hostStop), .devReq(devReq), .devReadyN(devReadyN),
    .outData(outData), .outValid(outValid), .outReady(outReady), .overflow(overflow),
    .burstDone(burstDone), .burstWords(burstWords)
  );

  // record every word that leaves the FIFO
  always @(negedge clk) begin
    if (rstN && outValid && outReady && recvCnt < 64) begin
      recv[recvCnt] = outData;
      recvCnt = recvCnt + 1;
    end
  end

  always @(posedge clk) begin
    cycles = cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic sendEdge(input logic [DW-1:0] w);
    tick(1);
    hostData = w;
    tick(2);
    hostStrobe = ~hostStrobe;
    tick(6);
    @(negedge clk);
  endtask

  task automatic popWord(input logic [DW-1:0] exp, input string tag);
    int waitCnt = 0;
    @(negedge clk);
    while (!outValid && waitCnt < 50) begin
      @(negedge clk);
      waitCnt++;
    end
    check(outValid && outData == exp, tag, outData, exp);
    @(posedge clk); #1;
    outReady = 1'b1;
    @(posedge clk); #1;
    outReady = 1'b0;
  endtask

  task automatic startBurst();
    int waitCnt = 0;
    @(negedge clk);
    while (!devReq && waitCnt < 50) begin
      @(negedge clk);
      waitCnt++;
    end
    check(devReq == 1'b1, "R2 request before burst", devReq, 1);
    tick(1);
    hostAckN = 1'b0;
    hostStop = 1'b0;
    tick(6);
  endtask

  task automatic endBurst(input int expWords, input string tag);
    int waitCnt = 0;
    tick(1);
    hostStop = 1'b1;
    @(negedge clk);
    while (!burstDone && waitCnt < 20) begin
      @(negedge clk);
      waitCnt++;
    end
    check(burstDone == 1'b1, {tag, " R7 done pulse"}, burstDone, 1);
    check(int'(burstWords) == expWords, {tag, " R7 word count"}, burstWords, expWords);
    check(!devReq && devReadyN, {tag, " R7 lines released"}, {devReq, devReadyN}, 2'b01);
    @(negedge clk);
    check(burstDone == 1'b0, {tag, " R7 single pulse"}, burstDone, 0);
    tick(1);
    hostAckN = 1'b1;
  endtask

  task automatic testReset();
    @(negedge clk);
    check(!devReq && devReadyN && !outValid && !overflow && !burstDone,
          "R1 reset outputs", {devReq, devReadyN, outValid, overflow, burstDone}, 5'b01000);
    tick(1);
    rstN = 1'b1;
    @(negedge clk);
    check(!devReq && devReadyN && !outValid && !overflow && !burstDone,
          "R1 first cycle after reset", {devReq, devReadyN, outValid, overflow, burstDone}, 5'b01000);
  endtask

  task automatic testRequestGate();
    tick(5);
    @(negedge clk);
    check(devReq == 1'b1, "R2 request raised when idle", devReq, 1);
    check(devReadyN == 1'b1, "R3 not ready before ack", devReadyN, 1);
    sendEdge(16'h1111);
    sendEdge(16'h2222);
    check(outValid == 1'b0, "R3 edges before ack ignored", outValid, 0);
    tick(1);
    hostAckN = 1'b0;
    sendEdge(16'h3333);
    check(devReadyN == 1'b1, "R3 not ready while stop held", devReadyN, 1);
    check(outValid == 1'b0, "R3 edge during stop ignored", outValid, 0);
    tick(1);
    hostStop = 1'b0;
    tick(6);
    @(negedge clk);
    check(devReadyN == 1'b0, "R5 ready once ack and stop released", devReadyN, 0);
    endBurst(0, "gate");
  endtask

  task automatic testThrottle();
    startBurst();
    for (int i = 0; i < 6; i++) begin
      sendEdge(16'hA000 + DW'(i));
      check(devReadyN == (i >= 5), "R5 ready versus free space", devReadyN, (i >= 5));
    end
    tick(400);
    @(negedge clk);
    check(devReq == 1'b1, "R6 burst open after long gap", devReq, 1);
    popWord(16'hA000, "R4 first word");
    popWord(16'hA001, "R4 second word");
    @(negedge clk);
    check(devReadyN == 1'b0, "R5 ready again after drain", devReadyN, 0);
    sendEdge(16'hA006);
    for (int i = 2; i < 7; i++) popWord(16'hA000 + DW'(i), "R4 R6 ordered drain");
    endBurst(7, "throttle");
  endtask

  task automatic testStream();
    startBurst();
    tick(1);
    outReady = 1'b1;
    recvCnt = 0;
    for (int i = 0; i < 6; i++) begin
      hostData = 16'hB000 + DW'(i);
      hostStrobe = ~hostStrobe;
      tick(1);
    end
    tick(10);
    outReady = 1'b0;
    check(recvCnt == 6, "R9 words out with concurrent pop", recvCnt, 6);
    for (int i = 0; i < 6; i++)
      check(recv[i] == 16'hB000 + DW'(i), "R9 order under push and pop", recv[i], 16'hB000 + i);
    check(overflow == 1'b0, "R9 no overflow", overflow, 0);
    endBurst(6, "stream");
    tick(4);
    @(negedge clk);
    check(devReq == 1'b1, "R7 back to idle and requesting", devReq, 1);
  endtask

  task automatic testOverflow();
    startBurst();
    for (int i = 0; i < 10; i++) sendEdge(16'hC000 + DW'(i));
    check(overflow == 1'b1, "R8 overflow set", overflow, 1);
    endBurst(8, "overflow");
    for (int i = 0; i < 8; i++) popWord(16'hC000 + DW'(i), "R8 kept words");
    tick(2);
    @(negedge clk);
    check(outValid == 1'b0, "R8 dropped words absent", outValid, 0);
    check(overflow == 1'b1, "R8 overflow sticky", overflow, 1);
  endtask

  initial begin
    testReset();
    testRequestGate();
    testThrottle();
    testStream();
    testOverflow();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule